// File: doc/BRIEF.md
# Searchable Store Buffer with Drain

This block is a small ring of pending processor stores that sits in front of a write-back L1 data cache. A store is written into the ring with its address and data and does not touch the cache arrays. A load presents its address on a combinational search port. When one or more buffered stores cover the same word, the load is answered from the ring with the data of the youngest such store. When no store covers the word, the block signals that the load must go to the cache tag and data lookup.

The oldest entry is offered to the cache over a valid/accept pair. It is offered only while the cache miss controller reports that it is idle and no load is using the cache arrays in that cycle. That gate is a lock that lasts one cycle: a load that misses in the ring sets it, and it clears by itself at the end of the cycle. The cache accepts the entry when it can. If the write misses in the cache, the cache side takes the entry over as its pending miss request. Inside this block that case is the same as any other accept.

Top module: `stq_drain_buf`

## Requirements
- R1: After reset the ring is empty. `st_ready` is 1, and `drain_valid`, `ld_hit` and `ld_cache_req` are 0.
- R2: A store is taken when `st_valid` and `st_ready` are both 1 at a rising clock edge. Stores leave the ring on the drain port in the order they were taken, and each keeps its full address and data.
- R3: `drain_valid` is 1 when the ring holds an entry, `ctrl_idle` is 1 and `ld_cache_req` is 0. While it is 1, `drain_addr` and `drain_data` show the oldest entry. That entry is removed at an edge where `drain_valid` and `drain_accept` are both 1.
- R4: A load with `ld_valid` at 1 hits when a buffered entry has the same address with bits [1:0] ignored. `ld_data` is then the data of the youngest matching entry.
- R5: A load with `ld_valid` at 1 that matches no entry gives `ld_hit` at 0 and `ld_cache_req` at 1. When `ld_valid` is 0, both are 0.
- R6: In a cycle where `ld_cache_req` is 1, `drain_valid` is 0 and no entry leaves the ring, even if `drain_accept` is 1.
- R7: While `ctrl_idle` is 0, `drain_valid` is 0 and no entry leaves the ring.
- R8: With 4 entries held, `st_ready` is 0. A store offered then is not taken and never appears on the drain port.
- R9: A store taken at the same edge as a drain removal is kept, and the number of entries stays the same.
- R10: The search sees only entries taken at earlier edges. A store offered in the same cycle as a load does not answer that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store word data |
| st_ready | output | 1 | Ring has a free entry |
| ld_valid | input | 1 | Load search request |
| ld_addr | input | 32 | Load byte address |
| ld_hit | output | 1 | Load answered from the ring |
| ld_data | output | 32 | Data of the youngest matching store |
| ld_cache_req | output | 1 | Load must use the cache arrays this cycle |
| ctrl_idle | input | 1 | Cache miss controller is idle |
| drain_valid | output | 1 | Oldest entry offered to the cache |
| drain_addr | output | 32 | Address of the oldest entry |
| drain_data | output | 32 | Data of the oldest entry |
| drain_accept | input | 1 | Cache takes the offered entry |

## Verification
Some properties are checked on every cycle. The entry count never exceeds the depth. A simultaneous store and drain leaves the count unchanged. A full ring stays full until something drains. A drain offer that was not accepted keeps its address. A load that goes to the cache never sees a drain offer in the same cycle, and a hit implies a live request on a non-empty ring. Other behaviour can only be shown by the bench scenarios, run against a reference queue. These are the youngest-match selection among stores to the same word with different low address bits, and the strict oldest-first drain order. They also include dropping a store offered while the ring is full, and a store that does not yet answer a load in its own cycle.

// File: rtl/stq_pkg.sv
package stq_pkg;
   localparam int STQ_ADDR_W = 32;
   localparam int STQ_DATA_W = 32;

   typedef struct packed {
      logic [STQ_ADDR_W-1:0] addr;
      logic [STQ_DATA_W-1:0] data;
   } stq_entry_t;
endpackage

// File: rtl/stq_ring_ctrl.sv
module stq_ring_ctrl #(
   parameter int DEPTH = 4,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enq,
   input  logic          deq,
   output logic [PW-1:0] head,
   output logic [PW-1:0] tail,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (enq) tail <= tail + PW'(1);
         if (deq) head <= head + PW'(1);
         case ({enq, deq})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R9
   enq_deq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq && deq) |=> $stable(count));
endmodule

// File: rtl/stq_youngest_match.sv
module stq_youngest_match #(
   parameter int DEPTH    = 4,
   parameter int OFS_BITS = 2,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  stq_pkg::stq_entry_t [DEPTH-1:0]        entries,
   input  logic [PW-1:0]                          head,
   input  logic [CW-1:0]                          count,
   input  logic                                   ld_valid,
   input  logic [stq_pkg::STQ_ADDR_W-1:0]         ld_addr,
   output logic                                   hit,
   output logic [stq_pkg::STQ_DATA_W-1:0]         data
);
   localparam int AW = stq_pkg::STQ_ADDR_W;

   logic [DEPTH-1:0] slot_match;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PW-1:0] age;
      logic          live;
      assign age  = PW'(i) - head;
      assign live = CW'(age) < count;
      assign slot_match[i] = ld_valid && live &&
         (entries[i].addr[AW-1:OFS_BITS] == ld_addr[AW-1:OFS_BITS]);
   end

   logic [PW-1:0] slot;
   always_comb begin
      hit  = 1'b0;
      data = '0;
      slot = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = head + PW'(k);
         if (slot_match[slot]) begin
            hit  = 1'b1;
            data = entries[slot].data;
         end
      end
   end

   // R4
   hit_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (ld_valid && count != '0));
endmodule

// File: rtl/stq_drain_buf.sv
module stq_drain_buf #(
   parameter int DEPTH    = 4,
   parameter int OFS_BITS = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           st_valid,
   input  logic [stq_pkg::STQ_ADDR_W-1:0] st_addr,
   input  logic [stq_pkg::STQ_DATA_W-1:0] st_data,
   output logic                           st_ready,
   input  logic                           ld_valid,
   input  logic [stq_pkg::STQ_ADDR_W-1:0] ld_addr,
   output logic                           ld_hit,
   output logic [stq_pkg::STQ_DATA_W-1:0] ld_data,
   output logic                           ld_cache_req,
   input  logic                           ctrl_idle,
   output logic                           drain_valid,
   output logic [stq_pkg::STQ_ADDR_W-1:0] drain_addr,
   output logic [stq_pkg::STQ_DATA_W-1:0] drain_data,
   input  logic                           drain_accept
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("stq_drain_buf: DEPTH must be a power of two of at least 2");
   end
   if (OFS_BITS < 0 || OFS_BITS >= stq_pkg::STQ_ADDR_W) begin : g_bad_ofs
      $error("stq_drain_buf: OFS_BITS out of range");
   end

   stq_pkg::stq_entry_t [DEPTH-1:0] entries;
   logic [PW-1:0] head, tail;
   logic [CW-1:0] count;
   logic          full, empty, enq, deq, l1_lock;

   assign st_ready = !full;
   assign enq      = st_valid && !full;

   stq_ring_ctrl #(.DEPTH(DEPTH)) ring_i (
      .clk(clk), .rst_n(rst_n), .enq(enq), .deq(deq),
      .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
   );

   always_ff @(posedge clk) begin
      if (enq) entries[tail] <= '{addr: st_addr, data: st_data};
   end

   stq_youngest_match #(.DEPTH(DEPTH), .OFS_BITS(OFS_BITS)) match_i (
      .clk(clk), .rst_n(rst_n), .entries(entries), .head(head), .count(count),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .hit(ld_hit), .data(ld_data)
   );

   // one-cycle lock: set by a load that goes to the cache, gone next cycle
   assign l1_lock      = ld_valid && !ld_hit;
   assign ld_cache_req = l1_lock;

   assign drain_valid = !empty && ctrl_idle && !l1_lock;
   assign drain_addr  = entries[head].addr;
   assign drain_data  = entries[head].data;
   assign deq         = drain_valid && drain_accept;

   // R6
   lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cache_req |-> !drain_valid);

   // R8
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_ready && !(drain_valid && drain_accept)) |=> !st_ready);

   // R3
   drain_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_valid && !drain_accept) |=> (!drain_valid || $stable(drain_addr)));
endmodule

// File: tb/stq_drain_buf_tb_top.sv
module stq_drain_buf_tb_top;
   localparam int CLK_P = 10;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 0, ld_valid = 0, ctrl_idle = 0, drain_accept = 0;
   logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0;
   logic        st_ready, ld_hit, ld_cache_req, drain_valid;
   logic [31:0] ld_data, drain_addr, drain_data;

   int n_chk = 0, n_bad = 0;
   logic [31:0] m_addr [DEPTH];
   logic [31:0] m_data [DEPTH];
   int m_cnt = 0;

   always #(CLK_P/2) clk = ~clk;

   stq_drain_buf #(.DEPTH(DEPTH), .OFS_BITS(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
      .st_data(st_data), .st_ready(st_ready), .ld_valid(ld_valid),
      .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
      .ld_cache_req(ld_cache_req), .ctrl_idle(ctrl_idle),
      .drain_valid(drain_valid), .drain_addr(drain_addr),
      .drain_data(drain_data), .drain_accept(drain_accept)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // youngest entry whose word address matches
   function automatic bit model_search(input logic [31:0] a, output logic [31:0] d);
      d = '0;
      for (int i = m_cnt - 1; i >= 0; i--) begin
         if (m_addr[i][31:2] == a[31:2]) begin
            d = m_data[i];
            return 1'b1;
         end
      end
      return 1'b0;
   endfunction

   task automatic step(input bit sv, input logic [31:0] sa, input logic [31:0] sd,
                       input bit lv, input logic [31:0] la, input bit idle, input bit acc);
      bit          e_hit, e_rdy, e_dv, e_lock;
      logic [31:0] e_ld;
      @(negedge clk);
      st_valid = sv; st_addr = sa; st_data = sd;
      ld_valid = lv; ld_addr = la; ctrl_idle = idle; drain_accept = acc;
      #1;
      e_hit  = lv && model_search(la, e_ld);
      e_lock = lv && !e_hit;
      e_rdy  = (m_cnt < DEPTH);
      e_dv   = (m_cnt > 0) && idle && !e_lock;
      chk(st_ready == e_rdy, "R8 st_ready", 32'(st_ready), 32'(e_rdy));
      chk(ld_hit == e_hit, "R4 R10 ld_hit", 32'(ld_hit), 32'(e_hit));
      if (e_hit) chk(ld_data == e_ld, "R4 ld_data", ld_data, e_ld);
      chk(ld_cache_req == e_lock, "R5 ld_cache_req", 32'(ld_cache_req), 32'(e_lock));
      if (e_lock && m_cnt > 0 && idle)
         chk(drain_valid == e_dv, "R6 drain_valid", 32'(drain_valid), 32'(e_dv));
      else if (!idle && m_cnt > 0)
         chk(drain_valid == e_dv, "R7 drain_valid", 32'(drain_valid), 32'(e_dv));
      else
         chk(drain_valid == e_dv, "R3 drain_valid", 32'(drain_valid), 32'(e_dv));
      if (e_dv) begin
         chk(drain_addr == m_addr[0], "R2 drain_addr", drain_addr, m_addr[0]);
         chk(drain_data == m_data[0], "R2 drain_data", drain_data, m_data[0]);
      end
      // model update for the coming edge (R9: both honoured)
      if (e_dv && acc) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            m_addr[i] = m_addr[i+1];
            m_data[i] = m_data[i+1];
         end
         m_cnt--;
      end
      if (sv && e_rdy) begin
         m_addr[m_cnt] = sa;
         m_data[m_cnt] = sd;
         m_cnt++;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 32'd1);
      chk(drain_valid == 1'b0, "R1 drain_valid", 32'(drain_valid), 32'd0);
      chk(ld_hit == 1'b0, "R1 ld_hit", 32'(ld_hit), 32'd0);
      chk(ld_cache_req == 1'b0, "R1 ld_cache_req", 32'(ld_cache_req), 32'd0);

      // R10: store and load to the same word in one cycle, no hit
      step(1, 32'h1000, 32'hA0A0_0001, 1, 32'h1000, 0, 0);
      // same word, different low bits, drain held by R7
      step(1, 32'h1001, 32'hB0B0_0002, 1, 32'h1003, 0, 0);
      step(1, 32'h1002, 32'hC0C0_0003, 0, 32'h0, 0, 1);
      step(1, 32'h1003, 32'hD0D0_0004, 0, 32'h0, 0, 1);
      // full: youngest match wins, R8 store dropped
      step(1, 32'h1004, 32'hEEEE_EEEE, 1, 32'h1002, 0, 0);
      // R6: load that misses blocks drain even with accept
      step(0, 0, 0, 1, 32'h2000, 1, 1);
      // R3: offered but not accepted
      step(0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 1, 32'h1000, 1, 1);
      // R9: enqueue and drain in the same cycle
      step(1, 32'h3000, 32'h3333_0005, 0, 0, 1, 1);
      step(1, 32'h3004, 32'h3333_0006, 0, 0, 0, 0);
      step(0, 0, 0, 1, 32'h3001, 0, 0);

      for (int n = 0; n < 4000; n++) begin
         logic [31:0] a_s, a_l;
         a_s = 32'h4000 + ($urandom % 6) * 4 + ($urandom % 4);
         a_l = 32'h4000 + ($urandom % 6) * 4 + ($urandom % 4);
         step(($urandom % 3) != 0, a_s, $urandom, ($urandom % 2) == 1, a_l,
              ($urandom % 4) != 0, ($urandom % 3) != 0);
      end

      for (int n = 0; n < 8; n++) step(0, 0, 0, 0, 0, 1, 1);
      chk(m_cnt == 0, "R2 drained", 32'(m_cnt), 32'd0);
      chk(drain_valid == 1'b0, "R3 empty", 32'(drain_valid), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule